// File: doc/BRIEF.md
# Pulse-Pair Position Decoder

This block sits on the receive side of an optical link where each data sample is carried by the time between two light pulses. It takes a stream of signed, digitised photodetector samples. It tracks and removes the slowly moving background level, then finds pulses by comparing the cleaned signal against a programmable threshold. The first pulse seen while idle is taken as a timing reference, and the next accepted pulse is taken as the data-bearing one. The number of clock cycles between them is reported as the decoded value, and a shorter spacing stands for a larger signal at the far end.

Spacings are accepted only inside a window. A pulse that comes too soon after the reference, inside the guard time, is thrown away and flagged, and the decoder goes on waiting for the real second pulse. If nothing arrives by the end of the window, the frame is flagged as missed and the next pulse starts a new pair. The background tracker is a shift-based running average. It holds still while a pulse is being handled, so a sudden change in light level costs at most one lost frame rather than a permanent loss of lock.

Top module: `ppd_decoder`

## Requirements
- R1: After reset, `dec_valid`, `flag_miss` and `flag_early` are low, `dec_spacing` is zero and the background estimate is zero.
- R2: On every valid sample x that is not frozen, the background estimate b becomes b + ((x - b) >>> BASE_SHIFT), using an arithmetic shift that rounds toward minus infinity. The estimate is frozen in the cycle of a pulse event and for the HOLDOFF cycles after it, and it never changes on a sample with `smp_valid` low.
- R3: A pulse event happens on a valid sample whose cleaned value (x - b) is strictly greater than the signed `thr_level`, provided the previous valid sample was not above the threshold. Rising crossings in the HOLDOFF cycles after an event are ignored.
- R4: While idle, an event is taken as the reference pulse. Spacing is the difference in clock-cycle index between a later event and the reference.
- R5: An event at spacing d with GUARD_CYC <= d <= WIN_CYC gives a one-cycle `dec_valid` in the cycle after that sample, with `dec_spacing` = d. The decoder then returns to idle.
- R6: An event at spacing d < GUARD_CYC gives a one-cycle `flag_early` in the cycle after that sample and is discarded. The decoder keeps waiting, and a later in-window event is still measured from the original reference.
- R7: If no event arrives by spacing WIN_CYC, a one-cycle `flag_miss` is raised in the cycle after the sample at spacing WIN_CYC. The next event becomes a new reference.
- R8: After a step in background level larger than the threshold, at most one frame is lost (one spurious reference that ends in a miss). Once the estimate settles, pairs decode with the correct spacing.
- R9: Samples with `smp_valid` low never cause an event, but spacing keeps counting clock cycles across them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed detector sample |
| thr_level | input | SAMPLE_W | Signed threshold over the background |
| dec_valid | output | 1 | One-cycle strobe for a decoded spacing |
| dec_spacing | output | $clog2(WIN_CYC+1) | Reference-to-data spacing in clock cycles |
| flag_miss | output | 1 | One-cycle strobe: no data pulse inside the window |
| flag_early | output | 1 | One-cycle strobe: pulse inside the guard time discarded |

## Verification
The bench sweeps the pulse spacing from 1 to beyond the window end and checks every cycle's outputs. This covers the hold-off edge (spacing HOLDOFF vs HOLDOFF+1), where a wrong counter would flag ringing as early pulses or swallow real ones. It also covers the guard and window edges, where an off-by-one would misclassify a boundary pulse as early, valid or missing. Threshold strictness is probed with pulses exactly at and one above the threshold. A very tall reference pulse is used to show the background freeze: without the freeze, the estimate jumps and the data pulse is missed. Steps of background level up and down show recovery after one lost frame. A masked sample that lies mid-frame must neither trigger a pulse nor drag the background.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_WAIT = 1'b1
   } ppd_phase_e;
endpackage

// File: rtl/ppd_baseline.sv
module ppd_baseline #(
   parameter int SAMPLE_W = 12,
   parameter int SHIFT    = 4,
   parameter bit TRACK_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] smp_data,
   input  logic                       freeze,
   output logic signed [SAMPLE_W:0]   diff
);
   localparam int DW = SAMPLE_W + 1;

   generate
      if (TRACK_EN) begin : g_track
         logic signed [SAMPLE_W-1:0] base_q;
         logic signed [DW-1:0]       delta;
         logic signed [DW-1:0]       nudge;
         logic signed [DW-1:0]       base_sum;

         always_comb begin
            delta    = {smp_data[SAMPLE_W-1], smp_data} - {base_q[SAMPLE_W-1], base_q};
            nudge    = delta >>> SHIFT;
            base_sum = {base_q[SAMPLE_W-1], base_q} + nudge;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               base_q <= '0;
            end else if (smp_valid && !freeze) begin
               base_q <= base_sum[SAMPLE_W-1:0];
            end
         end

         assign diff = delta;

         AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (freeze || !smp_valid) |=> $stable(base_q)) else $error("baseline moved while frozen"); // R2

         AST_BASE_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && !freeze) |=>
               ((base_q >= $past(base_q) && base_q <= $past(smp_data)) ||
                (base_q <= $past(base_q) && base_q >= $past(smp_data))))
            else $error("baseline step left the sample interval"); // R2
      end else begin : g_bypass
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ smp_valid ^ freeze;
         assign diff      = {smp_data[SAMPLE_W-1], smp_data};
      end
   endgenerate
endmodule

// File: rtl/ppd_pulse_detect.sv
module ppd_pulse_detect #(
   parameter int SAMPLE_W = 12,
   parameter int HOLDOFF  = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W:0]   diff,
   input  logic signed [SAMPLE_W-1:0] thr,
   output logic                       evt,
   output logic                       freeze
);
   localparam int HW = (HOLDOFF > 0) ? $clog2(HOLDOFF + 1) : 1;

   logic signed [SAMPLE_W:0] thr_ext;
   logic                     above;
   logic                     prev_q;
   logic                     rising;
   logic                     busy;

   assign thr_ext = {thr[SAMPLE_W-1], thr};
   assign above   = smp_valid && (diff > thr_ext);
   assign rising  = above && !prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
      end else if (smp_valid) begin
         prev_q <= above;
      end
   end

   generate
      if (HOLDOFF > 0) begin : g_hold
         logic [HW-1:0] hold_q;

         assign busy = (hold_q != '0);
         assign evt  = rising && !busy;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hold_q <= '0;
            end else if (evt) begin
               hold_q <= HW'(HOLDOFF);
            end else if (busy) begin
               hold_q <= hold_q - 1'b1;
            end
         end

         AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            evt |=> !evt) else $error("event inside hold-off"); // R3
      end else begin : g_nohold
         assign busy = 1'b0;
         assign evt  = rising;
      end
   endgenerate

   assign freeze = evt || busy;

   AST_EVT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> smp_valid) else $error("event on masked sample"); // R9
endmodule

// File: rtl/ppd_pair_fsm.sv
module ppd_pair_fsm
   import ppd_pkg::*;
#(
   parameter int GUARD_CYC = 150,
   parameter int WIN_CYC   = 450
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               evt,
   output logic                               dec_valid,
   output logic [$clog2(WIN_CYC+1)-1:0]       dec_spacing,
   output logic                               flag_miss,
   output logic                               flag_early
);
   localparam int SW = $clog2(WIN_CYC + 1);
   localparam logic [SW-1:0] GUARD_V = SW'(GUARD_CYC);
   localparam logic [SW-1:0] WIN_V   = SW'(WIN_CYC);

   ppd_phase_e    phase_q;
   logic [SW-1:0] cnt_q;
   logic [SW-1:0] spacing;

   assign spacing = cnt_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         cnt_q       <= '0;
         dec_valid   <= 1'b0;
         dec_spacing <= '0;
         flag_miss   <= 1'b0;
         flag_early  <= 1'b0;
      end else begin
         dec_valid  <= 1'b0;
         flag_miss  <= 1'b0;
         flag_early <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (evt) begin
                  phase_q <= PH_WAIT;
                  cnt_q   <= '0;
               end
            end
            PH_WAIT: begin
               if (evt && (spacing < GUARD_V)) begin
                  flag_early <= 1'b1;
                  cnt_q      <= spacing;
               end else if (evt) begin
                  dec_valid   <= 1'b1;
                  dec_spacing <= spacing;
                  phase_q     <= PH_IDLE;
               end else if (spacing == WIN_V) begin
                  flag_miss <= 1'b1;
                  phase_q   <= PH_IDLE;
               end else begin
                  cnt_q <= spacing;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   AST_VALUE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (dec_spacing >= GUARD_V && dec_spacing <= WIN_V)) else $error("spacing outside window"); // R5
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dec_valid, flag_miss, flag_early})) else $error("two outcomes at once"); // R7
   AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_WAIT) |-> (cnt_q < WIN_V)) else $error("wait ran past window"); // R7
   AST_EARLY_KEEPS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      flag_early |-> (phase_q == PH_WAIT)) else $error("early pulse ended the frame"); // R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid || flag_miss) |-> (phase_q == PH_IDLE)) else $error("frame did not close"); // R4
endmodule

// File: rtl/ppd_decoder.sv
module ppd_decoder #(
   parameter int SAMPLE_W   = 12,
   parameter int BASE_SHIFT = 4,
   parameter bit TRACK_BASE = 1'b1,
   parameter int HOLDOFF    = 3,
   parameter int GUARD_CYC  = 150,
   parameter int WIN_CYC    = 450,
   localparam int SPACING_W = $clog2(WIN_CYC + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] smp_data,
   input  logic signed [SAMPLE_W-1:0] thr_level,
   output logic                       dec_valid,
   output logic [SPACING_W-1:0]       dec_spacing,
   output logic                       flag_miss,
   output logic                       flag_early
);
   initial begin
      assert (SAMPLE_W >= 4) else $error("SAMPLE_W too small");
      assert (BASE_SHIFT >= 1 && BASE_SHIFT < SAMPLE_W) else $error("BASE_SHIFT out of range");
      assert (HOLDOFF >= 0) else $error("HOLDOFF negative");
      assert (GUARD_CYC >= 1) else $error("GUARD_CYC must be positive");
      assert (WIN_CYC > GUARD_CYC) else $error("window must end after guard");
   end

   logic signed [SAMPLE_W:0] clean;
   logic                     evt;
   logic                     freeze;

   ppd_baseline #(
      .SAMPLE_W (SAMPLE_W),
      .SHIFT    (BASE_SHIFT),
      .TRACK_EN (TRACK_BASE)
   ) u_base (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .freeze    (freeze),
      .diff      (clean)
   );

   ppd_pulse_detect #(
      .SAMPLE_W (SAMPLE_W),
      .HOLDOFF  (HOLDOFF)
   ) u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .diff      (clean),
      .thr       (thr_level),
      .evt       (evt),
      .freeze    (freeze)
   );

   ppd_pair_fsm #(
      .GUARD_CYC (GUARD_CYC),
      .WIN_CYC   (WIN_CYC)
   ) u_pair (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt         (evt),
      .dec_valid   (dec_valid),
      .dec_spacing (dec_spacing),
      .flag_miss   (flag_miss),
      .flag_early  (flag_early)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!dec_valid && !flag_miss && !flag_early)) else $error("outputs active after reset"); // R1
endmodule

// File: tb/ppd_decoder_tb.sv
`timescale 1ns/1ps
module ppd_decoder_tb;
   localparam int SW_T  = 12;
   localparam int SHF   = 3;
   localparam int HOLD  = 3;
   localparam int GUARD = 12;
   localparam int WIN   = 36;
   localparam int THR   = 100;
   localparam int SPW   = $clog2(WIN + 1);

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   smp_valid = 1'b0;
   logic signed [SW_T-1:0] smp_data = '0;
   logic signed [SW_T-1:0] thr_level = SW_T'(THR);
   logic                   dec_valid;
   logic [SPW-1:0]         dec_spacing;
   logic                   flag_miss;
   logic                   flag_early;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   ppd_decoder #(
      .SAMPLE_W   (SW_T),
      .BASE_SHIFT (SHF),
      .TRACK_BASE (1'b1),
      .HOLDOFF    (HOLD),
      .GUARD_CYC  (GUARD),
      .WIN_CYC    (WIN)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_valid   (smp_valid),
      .smp_data    (smp_data),
      .thr_level   (thr_level),
      .dec_valid   (dec_valid),
      .dec_spacing (dec_spacing),
      .flag_miss   (flag_miss),
      .flag_early  (flag_early)
   );

   task automatic send(input logic v, input int x);
      smp_valid = v;
      smp_data  = SW_T'(x);
      @(negedge clk);
   endtask

   task automatic check_cycle(input string req, input int i, input bit ev, input bit ee,
                              input bit em, input int val);
      bit bad;
      bad = (dec_valid !== ev) || (flag_early !== ee) || (flag_miss !== em) ||
            (ev && (int'(dec_spacing) != val));
      n_chk++;
      if (bad) begin
         n_fail++;
         $display("FAIL %s step %0d: got valid=%0b spacing=%0d early=%0b miss=%0b, expected valid=%0b spacing=%0d early=%0b miss=%0b",
                  req, i, dec_valid, dec_spacing, flag_early, flag_miss, ev, val, ee, em);
      end
   endtask

   task automatic idle(input string req, input int n, input int bg);
      for (int i = 0; i < n; i++) begin
         send(1'b1, bg);
         check_cycle(req, i, 1'b0, 1'b0, 1'b0, 0);
      end
   endtask

   // Reference pulse of height h1 (width pw1) at step 0, second pulse h2 at step d.
   task automatic run_pair(input string req, input int d, input int bg, input int h1,
                           input int pw1, input int h2);
      bit det1;
      bit det2;
      int len;
      det1 = (h1 > THR);
      det2 = (h2 > THR);
      len  = d + WIN + 3;
      for (int i = 0; i < len; i++) begin
         int x;
         bit ev;
         bit ee;
         bit em;
         x  = bg;
         ev = 1'b0;
         ee = 1'b0;
         em = 1'b0;
         if (i < pw1) x = bg + h1;
         if (i == d)  x = bg + h2;
         send(1'b1, x);
         if (det1) begin
            if (det2 && d >= GUARD && d <= WIN) begin
               ev = (i == d);
            end else begin
               if (det2 && d > HOLD && d < GUARD && i == d) ee = 1'b1;
               if (i == WIN) em = 1'b1;
               if (det2 && d > WIN && i == d + WIN) em = 1'b1;
            end
         end else if (det2 && i == d + WIN) begin
            em = 1'b1;
         end
         check_cycle(req, i, ev, ee, em, d);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, got hang, expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1: reset state
      check_cycle("R1", 0, 1'b0, 1'b0, 1'b0, 0);
      n_chk++;
      if (dec_spacing !== '0) begin
         n_fail++;
         $display("FAIL R1: spacing after reset got %0d expected 0", dec_spacing);
      end
      rst_n = 1'b1;
      idle("R1", 10, 0);

      // R3 R5 R6 R7: spacing sweep over hold-off, guard and window edges
      for (int d = 1; d <= WIN + 4; d++) begin
         string tag;
         if (d <= HOLD)       tag = "R3";
         else if (d < GUARD)  tag = "R6";
         else if (d <= WIN)   tag = "R5";
         else                 tag = "R7";
         run_pair(tag, d, 0, 150, 1, 150);
         idle("R4", 8, 0);
      end

      // R3: threshold is strict
      run_pair("R3", 20, 0, 100, 1, 100);
      idle("R3", 20, 0);
      run_pair("R3", 20, 0, 101, 1, 101);
      idle("R3", 10, 0);

      // R2: tall, wide reference pulse must not drag the background
      run_pair("R2", 20, 0, 2000, 3, 130);
      idle("R2", 10, 0);

      // R6: early pulse then in-window pulse against the same reference
      for (int i = 0; i < WIN + 3; i++) begin
         int x;
         x = (i == 0 || i == 6 || i == 20) ? 150 : 0;
         send(1'b1, x);
         check_cycle("R6", i, (i == 20), (i == 6), 1'b0, 20);
      end
      idle("R6", 10, 0);

      // R9: masked sample mid-frame is ignored, counting continues
      for (int i = 0; i < WIN + 3; i++) begin
         if (i == 10) send(1'b0, 1500);
         else         send(1'b1, (i == 0 || i == 25) ? 150 : 0);
         check_cycle("R9", i, (i == 25), 1'b0, 1'b0, 25);
      end
      idle("R9", 10, 0);

      // R8: background steps up, one lost frame, then clean decoding
      for (int i = 0; i < WIN + 150; i++) begin
         send(1'b1, 600);
         check_cycle("R8", i, 1'b0, 1'b0, (i == WIN), 0);
      end
      run_pair("R8", 20, 600, 300, 1, 300);
      idle("R8", 10, 600);
      run_pair("R8", GUARD, 600, 300, 1, 300);
      idle("R8", 10, 600);
      // R8: background steps down, no events, then clean decoding
      idle("R8", 150, 0);
      run_pair("R8", WIN, 0, 150, 1, 150);
      idle("R8", 5, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule